// File: doc/BRIEF.md
# Synchronous Burst SRAM Access Controller

This block is the control front end of a common-I/O synchronous static memory that stores 32-bit words as four byte lanes. Every control, address and data input is captured on the rising clock edge. Each edge either starts an access, continues an open burst, closes the burst or does nothing. Two address strobes can start an access: a processor strobe and a controller strobe. Both need three chip selects to be active. The processor strobe is gated by the first select and does not look at the write inputs in its first cycle. The controller strobe uses the write inputs in its first cycle to choose between a read and a write. A two-bit burst counter then steps through the four words of the aligned block, in linear or interleaved order.

The block contains a behavioural storage array with byte-lane write masks. A global write forces all four lanes. Read data is registered and appears on the outputs in the cycle after the read beat. The data pins are not driven directly. Instead, a drive-enable output tells the pad logic outside the block when to drive them. Drive-enable follows the asynchronous output enable and drops during writes, deselects and idle cycles.

Top module: `sbsram_ctrl`

## Requirements
- R1: All inputs are sampled on the rising clock edge. A read beat at edge k places the addressed word on `data_out` right after edge k, and it holds there until the next beat.
- R2: An access starts only when `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0 and a recognised strobe is low. A recognised strobe seen while any select is inactive closes the burst, and `data_drive` is 0 after that edge.
- R3: While `sel_a_n` is high, a low `proc_stb_n` is ignored. It neither starts nor ends an access, so an open burst carries on at its current address.
- R4: An access started by the processor strobe is a read of `addr`, whatever the write inputs are. This strobe takes precedence when both strobes are low. If the write inputs are active at the next edge, with no strobe and `adv_n`=1, `data_in` is written to that same address.
- R5: An access started by the controller strobe is a write in its first cycle if the write inputs qualify any lane, and a read otherwise.
- R6: When `all_wr_n`=0, all four lanes are written regardless of `byte_wr_n` and `lane_sel_n`.
- R7: When `all_wr_n`=1, lane i (bits 8i+7:8i) is written only when `byte_wr_n`=0 and `lane_sel_n[i]`=0. A beat that qualifies no lane is a read.
- R8: `data_drive` is 1 only after a read beat and only while `out_en_n`=0. It is 0 after a write beat, and it follows `out_en_n` without waiting for a clock edge.
- R9: On an edge with no recognised strobe and a burst open, `adv_n`=0 advances the two-bit counter before the beat and `adv_n`=1 repeats the current address. Either kind of beat, read or write, is chosen per edge by R6/R7.
- R10: With `burst_linear`=1, the low two address bits of a beat are (start + count) mod 4. With `burst_linear`=0 they are start XOR count. The upper address bits stay at the start address.
- R11: After reset, and after a deselect, edges with no recognised strobe perform no access and leave `data_drive` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| burst_linear | input | 1 | Static burst order: 1 linear, 0 interleaved |
| addr | input | ADDR_W | Word address captured at an access start |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| sel_a_n | input | 1 | First chip select, active low, also gates the processor strobe |
| sel_b | input | 1 | Second chip select, active high |
| sel_c_n | input | 1 | Third chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| all_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Byte-write enable, active low |
| lane_sel_n | input | LANES | Per-lane write select, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data_in | input | LANES*LANE_W | Write data |
| data_out | output | LANES*LANE_W | Registered read data |
| data_drive | output | 1 | Pad drive enable for `data_out` |

## Verification
The bound checker watches the port-level rules on every cycle. A deselecting strobe blanks the outputs. A processor start always becomes a read. A controller start becomes a read or a write as its write inputs dictate. A high output enable never lets the pad drive. Stored contents can only be seen through the bench's scenarios. These cover byte-lane merging under the two write qualifications, the write that follows a processor start, the address sequence in both burst orders including wraparound and held beats, and the proof that a gated processor strobe leaves an open burst on its old address.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int DEF_ADDR_W = 8;
    localparam int DEF_LANES  = 4;
    localparam int DEF_LANE_W = 8;
    // burst length of four words is part of the access behaviour
    localparam int BURST_W    = 2;

    typedef enum logic [1:0] {
        BEAT_NONE  = 2'd0,
        BEAT_READ  = 2'd1,
        BEAT_WRITE = 2'd2
    } beat_e;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } order_e;

    // low address bits of the current beat inside the aligned block
    function automatic logic [BURST_W-1:0] burst_lo(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] count,
        input order_e             ord
    );
        logic [BURST_W-1:0] res;
        if (ord == ORD_LINEAR) res = start + count;
        else                   res = start ^ count;
        return res;
    endfunction

endpackage

// File: rtl/sbsram_seq.sv
module sbsram_seq
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W
) (
    input  logic [ADDR_W-1:0]  base,
    input  logic [BURST_W-1:0] count,
    input  order_e             ord,
    output logic [ADDR_W-1:0]  beat_addr
);
    localparam int HI_W = ADDR_W - BURST_W;

    logic [HI_W-1:0]    hi_bits;
    logic [BURST_W-1:0] lo_bits;

    always_comb begin
        hi_bits   = base[ADDR_W-1:BURST_W];
        lo_bits   = burst_lo(base[BURST_W-1:0], count, ord);
        beat_addr = {hi_bits, lo_bits};
    end
endmodule

// File: rtl/sbsram_ctl.sv
module sbsram_ctl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               proc_stb_n,
    input  logic               ctrl_stb_n,
    input  logic               sel_a_n,
    input  logic               sel_b,
    input  logic               sel_c_n,
    input  logic               adv_n,
    input  logic               all_wr_n,
    input  logic               byte_wr_n,
    input  logic [LANES-1:0]   lane_sel_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  seq_addr,
    output logic [ADDR_W-1:0]  base_q,
    output logic [BURST_W-1:0] cnt_nxt,
    output beat_e              beat_kind,
    output logic [ADDR_W-1:0]  beat_addr,
    output logic [LANES-1:0]   beat_mask
);
    logic               open_q, open_d;
    logic [ADDR_W-1:0]  base_d;
    logic [BURST_W-1:0] cnt_q, cnt_d;
    logic               proc_seen, ctrl_seen, strobe, chip_on, wr_any;
    logic [LANES-1:0]   lane_q;

    // per-lane write qualification
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_q[i] = !all_wr_n || (!byte_wr_n && !lane_sel_n[i]);
    end

    always_comb begin
        proc_seen = !proc_stb_n && !sel_a_n;
        ctrl_seen = !ctrl_stb_n;
        strobe    = proc_seen || ctrl_seen;
        chip_on   = !sel_a_n && sel_b && !sel_c_n;
        wr_any    = |lane_q;
        cnt_nxt   = cnt_q + {{(BURST_W-1){1'b0}}, !adv_n};
    end

    always_comb begin
        open_d    = open_q;
        base_d    = base_q;
        cnt_d     = cnt_q;
        beat_kind = BEAT_NONE;
        beat_addr = seq_addr;
        beat_mask = lane_q;
        if (strobe) begin
            if (chip_on) begin
                open_d    = 1'b1;
                base_d    = addr;
                cnt_d     = '0;
                beat_addr = addr;
                if (proc_seen)   beat_kind = BEAT_READ;
                else if (wr_any) beat_kind = BEAT_WRITE;
                else             beat_kind = BEAT_READ;
            end else begin
                open_d = 1'b0;
            end
        end else if (open_q) begin
            cnt_d     = cnt_nxt;
            beat_kind = wr_any ? BEAT_WRITE : BEAT_READ;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            open_q <= open_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/sbsram_mem.sv
module sbsram_mem
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  beat_e                   beat_kind,
    input  logic [ADDR_W-1:0]       beat_addr,
    input  logic [LANES-1:0]        beat_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rvalid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic wr_en, rd_en;
    assign wr_en = (beat_kind == BEAT_WRITE);
    assign rd_en = (beat_kind == BEAT_READ);

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (wr_en && beat_mask[b])
                cells[beat_addr] <= wdata[b*LANE_W +: LANE_W];
        end

        always_ff @(posedge clk) begin
            if (rst)        out_q <= '0;
            else if (rd_en) out_q <= cells[beat_addr];
        end

        assign rdata[b*LANE_W +: LANE_W] = out_q;
    end

    always_ff @(posedge clk) begin
        if (rst) rvalid <= 1'b0;
        else     rvalid <= rd_en;
    end
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    burst_linear,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    proc_stb_n,
    input  logic                    ctrl_stb_n,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    adv_n,
    input  logic                    all_wr_n,
    input  logic                    byte_wr_n,
    input  logic [LANES-1:0]        lane_sel_n,
    input  logic                    out_en_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    output logic [LANES*LANE_W-1:0] data_out,
    output logic                    data_drive
);
    localparam int DATA_W = LANES * LANE_W;

    order_e             ord;
    logic [ADDR_W-1:0]  base_q, seq_addr, beat_addr;
    logic [BURST_W-1:0] cnt_nxt;
    beat_e              beat_kind;
    logic [LANES-1:0]   beat_mask;
    logic [DATA_W-1:0]  rd_word;
    logic               rd_valid;

    assign ord = burst_linear ? ORD_LINEAR : ORD_INTERLEAVE;

    sbsram_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
        .clk(clk), .rst(rst),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .adv_n(adv_n), .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n),
        .lane_sel_n(lane_sel_n), .addr(addr), .seq_addr(seq_addr),
        .base_q(base_q), .cnt_nxt(cnt_nxt), .beat_kind(beat_kind),
        .beat_addr(beat_addr), .beat_mask(beat_mask)
    );

    sbsram_seq #(.ADDR_W(ADDR_W)) u_seq (
        .base(base_q), .count(cnt_nxt), .ord(ord), .beat_addr(seq_addr)
    );

    sbsram_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .rst(rst), .beat_kind(beat_kind), .beat_addr(beat_addr),
        .beat_mask(beat_mask), .wdata(data_in), .rdata(rd_word),
        .rvalid(rd_valid)
    );

    // output enable acts without a clock
    assign data_out   = rd_word;
    assign data_drive = rd_valid && !out_en_n;
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             proc_stb_n,
    input logic             ctrl_stb_n,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             all_wr_n,
    input logic             byte_wr_n,
    input logic [LANES-1:0] lane_sel_n,
    input logic             out_en_n,
    input logic             data_drive,
    input logic             rd_valid
);
    logic chip_on, strobe, wr_req;
    assign chip_on = !sel_a_n && sel_b && !sel_c_n;
    assign strobe  = (!proc_stb_n && !sel_a_n) || !ctrl_stb_n;
    assign wr_req  = !all_wr_n || (!byte_wr_n && (lane_sel_n != {LANES{1'b1}}));

    a_r2_deselect_blanks: assert property (@(posedge clk) disable iff (rst)
        (strobe && !chip_on) |=> !data_drive);

    a_r4_proc_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!proc_stb_n && chip_on) |=> rd_valid);

    a_r5_ctrl_start_reads: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_stb_n && proc_stb_n && chip_on && !wr_req) |=> rd_valid);

    a_r5_ctrl_start_writes: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_stb_n && proc_stb_n && chip_on && wr_req) |=> !rd_valid);

    a_r8_oe_blocks_drive: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !data_drive);
endmodule

bind sbsram_ctrl sbsram_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
    .out_en_n(out_en_n), .data_drive(data_drive), .rd_valid(rd_valid)
);

// File: tb/sim_sbsram_ctrl.sv
`timescale 1ns/1ps
module sim_sbsram_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        burst_linear;
    logic [7:0]  addr;
    logic        proc_stb_n, ctrl_stb_n, sel_a_n, sel_b, sel_c_n, adv_n;
    logic        all_wr_n, byte_wr_n, out_en_n;
    logic [3:0]  lane_sel_n;
    logic [31:0] data_in, data_out;
    logic        data_drive;

    int total = 0;
    int bad   = 0;
    logic [31:0] ref_mem [256];

    always #2 clk = ~clk;

    sbsram_ctrl u0 (
        .clk(clk), .rst(rst), .burst_linear(burst_linear), .addr(addr),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .adv_n(adv_n),
        .all_wr_n(all_wr_n), .byte_wr_n(byte_wr_n), .lane_sel_n(lane_sel_n),
        .out_en_n(out_en_n), .data_in(data_in), .data_out(data_out),
        .data_drive(data_drive)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_idle();
        proc_stb_n = 1; ctrl_stb_n = 1; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        adv_n = 1; all_wr_n = 1; byte_wr_n = 1; lane_sel_n = 4'hF;
        out_en_n = 0; addr = 8'h00; data_in = 32'h0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // controller-strobe start with the given write inputs
    task automatic ctrl_beat(input logic [7:0] a, input logic [31:0] d,
                             input logic gw_n, input logic bw_n, input logic [3:0] ls_n);
        logic [3:0] m;
        set_idle();
        ctrl_stb_n = 0; addr = a; data_in = d;
        all_wr_n = gw_n; byte_wr_n = bw_n; lane_sel_n = ls_n;
        for (int i = 0; i < 4; i++) m[i] = !gw_n || (!bw_n && !ls_n[i]);
        step();
        if (m == 4'h0) begin
            chk(data_drive === 1'b1, "R7 no-lane beat reads", {31'h0, data_drive}, 32'h1);
        end else begin
            chk(data_drive === 1'b0, "R8 write beat no drive", {31'h0, data_drive}, 32'h0);
            for (int i = 0; i < 4; i++)
                if (m[i]) ref_mem[a][i*8 +: 8] = d[i*8 +: 8];
        end
        set_idle();
    endtask

    task automatic rd_check(input logic [7:0] a, input string tag);
        set_idle();
        ctrl_stb_n = 0; addr = a;
        step();
        chk(data_drive === 1'b1 && data_out === ref_mem[a], tag, data_out, ref_mem[a]);
        set_idle();
    endtask

    function automatic logic [7:0] exp_addr(input logic [7:0] s, input logic [1:0] c, input bit lin);
        logic [1:0] lo;
        lo = lin ? s[1:0] + c : s[1:0] ^ c;
        return {s[7:2], lo};
    endfunction

    task automatic t_reset();
        chk(data_drive === 1'b0, "R11 reset no drive", {31'h0, data_drive}, 32'h0);
    endtask

    task automatic t_words();
        ctrl_beat(8'h10, 32'h11223344, 0, 1, 4'hF);
        rd_check(8'h10, "R5/R1 full write read back");
        ctrl_beat(8'h10, 32'hAABBCCDD, 1, 0, 4'b1010);
        rd_check(8'h10, "R7 lanes 0 and 2 merged");
        chk(ref_mem[8'h10] == 32'h11BB33DD, "R7 expected merge", ref_mem[8'h10], 32'h11BB33DD);
        ctrl_beat(8'h10, 32'hFFFFFFFF, 1, 1, 4'h0);
        rd_check(8'h10, "R7 byte enable off keeps word");
        ctrl_beat(8'h10, 32'h0BADF00D, 0, 1, 4'hF);
        rd_check(8'h10, "R6 global write all lanes");
    endtask

    task automatic t_proc();
        ctrl_beat(8'h20, 32'h01020304, 0, 1, 4'hF);
        set_idle();
        proc_stb_n = 0; ctrl_stb_n = 0; addr = 8'h20; all_wr_n = 0; data_in = 32'h5555AAAA;
        step();
        chk(data_drive === 1'b1 && data_out === 32'h01020304, "R4 proc start reads", data_out, 32'h01020304);
        proc_stb_n = 1; ctrl_stb_n = 1; adv_n = 1; all_wr_n = 0; data_in = 32'h5555AAAA;
        step();
        chk(data_drive === 1'b0, "R4 second cycle writes", {31'h0, data_drive}, 32'h0);
        ref_mem[8'h20] = 32'h5555AAAA;
        rd_check(8'h20, "R4 write landed");
    endtask

    task automatic t_gated();
        ctrl_beat(8'h30, 32'h33333333, 0, 1, 4'hF);
        ctrl_beat(8'h34, 32'h44444444, 0, 1, 4'hF);
        rd_check(8'h30, "R3 setup read");
        proc_stb_n = 0; sel_a_n = 1; addr = 8'h34;
        step();
        chk(data_drive === 1'b1 && data_out === ref_mem[8'h30], "R3 gated proc strobe ignored",
            data_out, ref_mem[8'h30]);
        set_idle();
    endtask

    task automatic t_deselect();
        rd_check(8'h30, "R2 setup read");
        ctrl_stb_n = 0; sel_b = 0; addr = 8'h30;
        step();
        chk(data_drive === 1'b0, "R2 sel_b off deselects", {31'h0, data_drive}, 32'h0);
        set_idle(); adv_n = 0;
        step();
        chk(data_drive === 1'b0, "R2 burst closed", {31'h0, data_drive}, 32'h0);
        ctrl_stb_n = 0; sel_c_n = 1;
        step();
        chk(data_drive === 1'b0, "R2 sel_c_n off deselects", {31'h0, data_drive}, 32'h0);
        set_idle(); proc_stb_n = 0; sel_b = 0;
        step();
        chk(data_drive === 1'b0, "R2 proc strobe without sel_b", {31'h0, data_drive}, 32'h0);
        set_idle(); all_wr_n = 0; data_in = 32'hDEADBEEF;
        for (int k = 0; k < 3; k++) begin
            step();
            chk(data_drive === 1'b0, "R11 idle edges no access", {31'h0, data_drive}, 32'h0);
        end
        set_idle();
        rd_check(8'h30, "R11 idle write inputs ignored");
    endtask

    task automatic t_burst(input bit lin, input logic [7:0] s, input string tag);
        logic [1:0] c;
        logic [7:0] ea;
        bit adv_seq [5];
        adv_seq = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
        burst_linear = lin;
        rd_check(s, tag);
        c = 2'd0;
        for (int k = 0; k < 5; k++) begin
            ctrl_stb_n = 1; adv_n = adv_seq[k];
            if (!adv_seq[k]) c = c + 2'd1;
            step();
            ea = exp_addr(s, c, lin);
            chk(data_drive === 1'b1 && data_out === ref_mem[ea], tag, data_out, ref_mem[ea]);
        end
        set_idle();
    endtask

    task automatic t_burst_write();
        burst_linear = 1;
        rd_check(8'h40, "R9 write burst start");
        adv_n = 0; all_wr_n = 0; data_in = 32'hCAFE0001;
        step();
        chk(data_drive === 1'b0, "R9 advanced write beat", {31'h0, data_drive}, 32'h0);
        ref_mem[8'h41] = 32'hCAFE0001;
        set_idle();
        rd_check(8'h41, "R9 advanced write landed");
        rd_check(8'h40, "R9 start word untouched");
    endtask

    task automatic t_oe();
        rd_check(8'h42, "R8 setup read");
        out_en_n = 1; #1;
        chk(data_drive === 1'b0, "R8 oe high blocks drive", {31'h0, data_drive}, 32'h0);
        out_en_n = 0; #1;
        chk(data_drive === 1'b1, "R8 oe low restores drive", {31'h0, data_drive}, 32'h1);
        set_idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) ref_mem[i] = 32'h0;
        set_idle();
        burst_linear = 1;
        rst = 1;
        repeat (3) step();
        rst = 0;
        step();
        t_reset();
        t_words();
        t_proc();
        t_gated();
        t_deselect();
        for (int i = 0; i < 4; i++)
            ctrl_beat(8'h40 + 8'(i), 32'hA0A0_0000 + 32'(i * 17 + 1), 0, 1, 4'hF);
        t_burst(1'b1, 8'h42, "R10 R9 linear burst");
        t_burst(1'b0, 8'h41, "R10 R9 interleaved burst");
        t_burst_write();
        t_oe();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule